// File: doc/BRIEF.md
# Serial Register Write Interface for a Multiplexed 7-Segment Display Controller

This block terminates a four-wire serial command link (serial clock, serial data, a load strobe that doubles as an active-low select, and a serial data output) and holds the register file that a 7-segment scan engine reads. The host shifts 16-bit command words in, most significant bit first. A rising edge on the load strobe turns the word just received into a write to one register: one of eight digit registers, or one of the control registers (decode enable, intensity, scan limit, shutdown, feature, display test).

The serial inputs are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and its edges are found in the system clock domain. Bits leave the shift register on a serial output that changes on falling serial clock edges, so controllers can be chained. The host sends the command for the far controller first and follows it with no-op words for the nearer ones, then raises the load strobe once for the whole chain.

Top module: `segdisp_regif`

## Requirements
- R1: A frame is 16 bits, shifted in most significant bit first on rising serial clock edges. Bits 11:8 select the register and bits 7:0 carry the data. Bits 15:12 have no effect.
- R2: The write happens on a rising edge of the load strobe, and only if at least 16 honoured rising serial clock edges have arrived since the previous load rising edge (or reset). The last 16 bits shifted in form the word. With fewer bits no register changes.
- R3: Addresses 1 to 8 write digit registers 0 to 7. Digit k appears on `digits_o[8k+7:8k]`.
- R4: Address 9 writes all 8 bits of `decode_en_o`. Address A writes data bits 3:0 to `intensity_o`. Address B writes data bits 2:0 to `scan_limit_o`. Address F writes data bit 0 to `disp_test_o`.
- R5: Addresses 0 (no-op) and D change no register.
- R6: Address C sets `run_o` to data bit 0 (1 = normal operation, 0 = shutdown). If data bit 7 is 0, the same write clears `feature_o` to zero. If data bit 7 is 1, `feature_o` is kept.
- R7: Address E stores all 8 data bits in `feature_o`. If data bit 1 is 1, the same write returns decode enable, intensity, scan limit, run and display test to their reset values. The digit registers keep their contents.
- R8: After reset every register output is zero: shutdown, a one-digit scan limit, no decoding, minimum intensity, feature 0, display test off, and the digits cleared. `ser_dout` is 0.
- R9: The bit that enters on the m-th honoured rising serial edge is driven on `ser_dout` from the falling serial edge after honoured rising edge m+15. `ser_dout` changes only after falling serial edges and is always driven.
- R10: While feature bit 3 is 1, rising and falling serial clock edges that occur while the load strobe is high are ignored. While feature bit 3 is 0, they are honoured regardless of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock (asynchronous) |
| ser_din | input | 1 | Serial data input |
| ser_load | input | 1 | Load strobe / active-low select |
| ser_dout | output | 1 | Serial data output for chaining |
| digits_o | output | 64 | Eight digit registers, digit k at bits 8k+7:8k |
| decode_en_o | output | 8 | Per-digit decode enable |
| intensity_o | output | 4 | Brightness step |
| scan_limit_o | output | 3 | Highest scanned digit index |
| run_o | output | 1 | 1 = normal operation, 0 = shutdown |
| feature_o | output | 8 | Feature register |
| disp_test_o | output | 1 | Display test enable |

## Verification
A load strobe edge reaches the registers on the third system clock rising edge after the strobe changes: two synchroniser stages, then the register itself. The bench's behavioural model applies each write right after that third edge. It compares every register output with the model on every falling system clock edge. The serial output is due about three system clocks after a falling serial edge. The bench samples it just before each rising serial edge, at least eight system clocks later, against the bit that entered 16 honoured edges earlier. The serial half period of eight system clocks keeps every synchronised edge apart, so no result depends on edges arriving in the same cycle.

// File: rtl/segdisp_regif.sv
module segdisp_regif #(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_W     = 16,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int NUM_DIG     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ser_clk,
  input  logic                        ser_din,
  input  logic                        ser_load,
  output logic                        ser_dout,
  output logic [NUM_DIG*DATA_W-1:0]   digits_o,
  output logic [DATA_W-1:0]           decode_en_o,
  output logic [3:0]                  intensity_o,
  output logic [2:0]                  scan_limit_o,
  output logic                        run_o,
  output logic [DATA_W-1:0]           feature_o,
  output logic                        disp_test_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [ADDR_W-1:0] A_DECODE = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_INTENS = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_SCAN   = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] A_SHDN   = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_FEAT   = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] A_TEST   = ADDR_W'(15);

  logic [SYNC_STAGES-1:0] sck_q, din_q, ld_q;
  logic                   sck_d, ld_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      din_q <= '0;
      ld_q  <= '0;
      sck_d <= 1'b0;
      ld_d  <= 1'b0;
    end else begin
      sck_q <= {sck_q[SYNC_STAGES-2:0], ser_clk};
      din_q <= {din_q[SYNC_STAGES-2:0], ser_din};
      ld_q  <= {ld_q[SYNC_STAGES-2:0], ser_load};
      sck_d <= sck_q[SYNC_STAGES-1];
      ld_d  <= ld_q[SYNC_STAGES-1];
    end

  wire sck_s  = sck_q[SYNC_STAGES-1];
  wire ld_s   = ld_q[SYNC_STAGES-1];
  wire din_s  = din_q[SYNC_STAGES-1];

  logic [DATA_W-1:0] feature_q;
  wire gate_ok   = !feature_q[3] || !ld_s;
  wire sck_rise  = gate_ok && sck_s && !sck_d;
  wire sck_fall  = gate_ok && !sck_s && sck_d;
  wire ld_rise   = ld_s && !ld_d;

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic               dout_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg  <= '0;
      cnt    <= '0;
      dout_q <= 1'b0;
    end else begin
      if (sck_rise) shreg <= {shreg[FRAME_W-2:0], din_s};
      if (ld_rise) cnt <= '0;
      else if (sck_rise && cnt != CNT_W'(FRAME_W)) cnt <= cnt + 1'b1;
      if (sck_fall) dout_q <= shreg[FRAME_W-1];
    end

  assign ser_dout = dout_q;

  wire                commit = ld_rise && (cnt == CNT_W'(FRAME_W));
  wire [ADDR_W-1:0]   addr   = shreg[DATA_W+ADDR_W-1:DATA_W];
  wire [DATA_W-1:0]   data   = shreg[DATA_W-1:0];
  wire                reg_reset = commit && addr == A_FEAT && data[1];

  logic [DATA_W-1:0] decode_q;
  logic [3:0]        intens_q;
  logic [2:0]        scan_q;
  logic              run_q, test_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      decode_q <= '0;
      intens_q <= '0;
      scan_q   <= '0;
      run_q    <= 1'b0;
      test_q   <= 1'b0;
    end else if (reg_reset) begin
      decode_q <= '0;
      intens_q <= '0;
      scan_q   <= '0;
      run_q    <= 1'b0;
      test_q   <= 1'b0;
    end else if (commit) begin
      case (addr)
        A_DECODE: decode_q <= data;
        A_INTENS: intens_q <= data[3:0];
        A_SCAN:   scan_q   <= data[2:0];
        A_SHDN:   run_q    <= data[0];
        A_TEST:   test_q   <= data[0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) feature_q <= '0;
    else if (commit && addr == A_FEAT) feature_q <= data;
    else if (commit && addr == A_SHDN && !data[DATA_W-1]) feature_q <= '0;

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_digit
    logic [DATA_W-1:0] dig_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) dig_q <= '0;
      else if (commit && addr == ADDR_W'(g + 1)) dig_q <= data;
    assign digits_o[g*DATA_W +: DATA_W] = dig_q;
  end

  assign decode_en_o  = decode_q;
  assign intensity_o  = intens_q;
  assign scan_limit_o = scan_q;
  assign run_o        = run_q;
  assign feature_o    = feature_q;
  assign disp_test_o  = test_q;

  wire [DATA_W+8:0] ctrl_all = {decode_q, intens_q, scan_q, run_q, test_q};

  AST_SHORT_FRAME_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rise && cnt != CNT_W'(FRAME_W) |=> $stable(digits_o) && $stable(ctrl_all) && $stable(feature_o)); // R2
  AST_NOOP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    commit && (addr == '0 || addr == ADDR_W'(13)) |=> $stable(digits_o) && $stable(ctrl_all) && $stable(feature_o)); // R5
  AST_SHDN_CLEARS_FEATURE: assert property (@(posedge clk) disable iff (!rst_n)
    commit && addr == A_SHDN && !shreg[DATA_W-1] |=> feature_o == '0); // R6
  AST_SHDN_KEEPS_FEATURE: assert property (@(posedge clk) disable iff (!rst_n)
    commit && addr == A_SHDN && shreg[DATA_W-1] |=> $stable(feature_o)); // R6
  AST_REG_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    commit && addr == A_FEAT && shreg[1] |=> ctrl_all == '0 && $stable(digits_o)); // R7
  AST_DOUT_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(ser_dout)); // R9
  AST_SELECT_GATES_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    feature_q[3] && ld_s |=> $stable(shreg)); // R10
endmodule

// File: tb/segdisp_regif_bench.sv
module segdisp_regif_bench;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_din = 1'b0, ser_load = 1'b1;
  logic ser_dout;
  logic [63:0] digits_o;
  logic [7:0]  decode_en_o, feature_o;
  logic [3:0]  intensity_o;
  logic [2:0]  scan_limit_o;
  logic        run_o, disp_test_o;

  always #4 clk = ~clk;

  segdisp_regif u_segdisp_regif (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_load(ser_load), .ser_dout(ser_dout), .digits_o(digits_o),
    .decode_en_o(decode_en_o), .intensity_o(intensity_o),
    .scan_limit_o(scan_limit_o), .run_o(run_o), .feature_o(feature_o),
    .disp_test_o(disp_test_o));

  int checks = 0, fails = 0;
  bit done = 0;

  bit        hist[$];
  int        mcnt = 0;
  logic [7:0] exp_dig[8];
  logic [7:0] exp_dec = 0, exp_feat = 0;
  logic [3:0] exp_int = 0;
  logic [2:0] exp_scan = 0;
  logic       exp_run = 0, exp_test = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_digits();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = exp_dig[k];
    return v;
  endfunction

  task automatic model_commit();
    logic [15:0] w;
    int n;
    if (mcnt == 16) begin
      n = hist.size();
      for (int i = 0; i < 16; i++) w[i] = hist[n-1-i];
      case (w[11:8])
        4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8: exp_dig[w[11:8]-1] = w[7:0];
        4'h9: exp_dec = w[7:0];
        4'hA: exp_int = w[3:0];
        4'hB: exp_scan = w[2:0];
        4'hC: begin exp_run = w[0]; if (!w[7]) exp_feat = 8'h00; end
        4'hE: begin
          exp_feat = w[7:0];
          if (w[1]) begin exp_dec = 0; exp_int = 0; exp_scan = 0; exp_run = 0; exp_test = 0; end
        end
        4'hF: exp_test = w[0];
        default: ;
      endcase
    end
    mcnt = 0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    bit honoured;
    int n;
    ser_din = b;
    tick(HALF);
    n = hist.size();
    chk("R9 dout before rise", 64'(ser_dout), 64'(n >= 16 ? hist[n-16] : 1'b0));
    honoured = !exp_feat[3] || !ser_load;
    ser_clk = 1'b1;
    if (honoured) begin
      hist.push_back(b);
      if (mcnt < 16) mcnt++;
    end
    tick(HALF);
    ser_clk = 1'b0;
    tick(HALF);
  endtask

  task automatic latch();
    ser_load = 1'b1;
    repeat (3) @(posedge clk);
    #1 model_commit();
    tick(HALF);
  endtask

  task automatic send_bits(input logic [31:0] w, input int nb);
    ser_load = 1'b0;
    tick(HALF);
    for (int i = nb - 1; i >= 0; i--) send_bit(w[i]);
    latch();
  endtask

  task automatic send_word(input logic [3:0] junk, input logic [3:0] a, input logic [7:0] d);
    send_bits({16'h0, junk, a, d}, 16);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 digits", digits_o, exp_digits());
      chk("R4 decode", 64'(decode_en_o), 64'(exp_dec));
      chk("R4 intensity", 64'(intensity_o), 64'(exp_int));
      chk("R4 scan limit", 64'(scan_limit_o), 64'(exp_scan));
      chk("R4 display test", 64'(disp_test_o), 64'(exp_test));
      chk("R6 run", 64'(run_o), 64'(exp_run));
      chk("R6 feature", 64'(feature_o), 64'(exp_feat));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) exp_dig[k] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(6);
    // R8 reset values
    chk("R8 digits", digits_o, 64'h0);
    chk("R8 control", 64'({decode_en_o, intensity_o, scan_limit_o, run_o, disp_test_o}), 64'h0);
    chk("R8 feature", 64'(feature_o), 64'h0);
    chk("R8 dout", 64'(ser_dout), 64'h0);

    // R1 R3 digit writes with junk in the top nibble
    for (int k = 0; k < 8; k++) send_word(4'hA ^ 4'(k), 4'(k + 1), 8'h11 * 8'(k + 1));
    chk("R1 R3 all digits", digits_o, 64'h8877665544332211);

    // R4 control registers
    send_word(4'h5, 4'h9, 8'hA5);
    send_word(4'hF, 4'hA, 8'h3C);
    send_word(4'h0, 4'hB, 8'hFD);
    send_word(4'h3, 4'hF, 8'h01);
    chk("R4 decode", 64'(decode_en_o), 64'hA5);
    chk("R4 intensity", 64'(intensity_o), 64'hC);
    chk("R4 scan", 64'(scan_limit_o), 64'h5);
    chk("R4 test", 64'(disp_test_o), 64'h1);

    // R6 shutdown and feature interaction
    send_word(4'h0, 4'hE, 8'h55);
    chk("R6 feature set", 64'(feature_o), 64'h55);
    send_word(4'h0, 4'hC, 8'h81);
    chk("R6 keep feature", 64'(feature_o), 64'h55);
    chk("R6 run on", 64'(run_o), 64'h1);
    send_word(4'h0, 4'hC, 8'h01);
    chk("R6 clear feature", 64'(feature_o), 64'h00);
    send_word(4'h0, 4'hE, 8'h14);
    send_word(4'h0, 4'hC, 8'h00);
    chk("R6 shutdown clears", 64'({run_o, feature_o}), 64'h000);

    // R5 no-op and unused address
    send_word(4'hF, 4'h0, 8'hFF);
    send_word(4'hF, 4'hD, 8'hFF);
    chk("R5 digits kept", digits_o, 64'h8877665544332211);
    chk("R5 control kept", 64'({decode_en_o, intensity_o, scan_limit_o, disp_test_o, feature_o}),
        64'({8'hA5, 4'hC, 3'h5, 1'b1, 8'h00}));

    // R2 short frame dropped, long frame uses last 16 bits
    send_bits(32'h3FF, 10);
    chk("R2 short frame", digits_o, 64'h8877665544332211);
    send_bits(32'h50399, 20);
    chk("R2 long frame", digits_o, 64'h8877665544992211);

    // R7 register reset through feature bit 1
    send_word(4'h0, 4'hC, 8'h81);
    chk("R7 precondition run", 64'(run_o), 64'h1);
    send_word(4'h0, 4'hE, 8'h02);
    chk("R7 control defaults", 64'({decode_en_o, intensity_o, scan_limit_o, run_o, disp_test_o}), 64'h0);
    chk("R7 feature stored", 64'(feature_o), 64'h02);
    chk("R7 digits kept", digits_o, 64'h8877665544992211);

    // R10 select gating of the serial clock
    send_word(4'h0, 4'hE, 8'h08);
    send_word(4'h0, 4'h8, 8'h3C);
    chk("R10 write with select low", digits_o, 64'h3C77665544992211);
    ser_load = 1'b1;
    tick(HALF);
    for (int i = 15; i >= 0; i--) send_bit(16'h06EE >> i);
    ser_load = 1'b0;
    tick(HALF);
    latch();
    chk("R10 clocks ignored while high", digits_o, 64'h3C77665544992211);
    send_word(4'h0, 4'hE, 8'h00);
    ser_load = 1'b1;
    tick(HALF);
    for (int i = 15; i >= 0; i--) send_bit(16'h06EE >> i);
    ser_load = 1'b0;
    tick(HALF);
    latch();
    chk("R10 clocks honoured outside select mode", digits_o, 64'h3C77EE5544992211);

    // R9 chain: the word goes out through dout behind a no-op
    send_bits({16'h0605, 16'h0000}, 32);
    send_bit(1'b0);
    chk("R9 dout idle after chain", 64'(ser_dout), 64'(hist[hist.size()-16]));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule